// File: doc/BRIEF.md
# Memory Self-Test with Serial Read-Back Check

This block wraps a small single-port memory with a built-in self-test. In functional mode the memory is driven straight from the primary write/read ports. When the test-mode input is high and a start pulse arrives, a controller takes over the memory port. It fills each address in turn with a byte from a maximal-length shift-register pattern generator and reads that byte back. The read-back value goes out on a serial line as a frame with start, parity and stop bits.

The serial line leaves the block on `ser_out` and returns on `ser_in`. Normally the two are tied together outside the block, so a fault anywhere on the loop shows up in the results. A receiver rebuilds the byte from each returning frame and checks its parity and stop bit. The controller then compares the byte against both the generated pattern and the memory output. It records the outcome in an 8-bit status register, and at the end it raises `done` and the go/no-go result `go`.

A fault model is built into the memory for test purposes. When parameters enable it, one bit of one address reads back as a fixed value. This lets a bench confirm that a defective array is reported as no-go.

Top module: `mbist_frame_top`

## Requirements
- R1: After reset `status` is 8'h00, `done` and `go` are low, and `ser_out` idles high.
- R2: With `test_mode` low, `fn_we` writes `fn_wdata` to `fn_addr` on a rising clock edge. `fn_rdata` shows the word at `fn_addr` one clock after the address is applied.
- R3: While `test_mode` is high, `fn_we`, `fn_addr` and `fn_wdata` have no effect on the memory. A `start` pulse is ignored while `test_mode` is low or a test is already running.
- R4: The pattern for word 0 is SEED (default 8'hA5). Each following pattern is the previous one shifted left by one, with the new bit 0 equal to the XOR of old bits 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1). Pattern i is written to address i for i = 0 to NUM_PAT-1.
- R5: Each read-back word is sent on `ser_out` as 11 bits, each lasting CLKS_PER_BIT clocks (default 4). The order is: a low start bit, the data bits LSB first, an even-parity bit (the XOR of the data bits), then a high stop bit. The line is high whenever no test is running.
- R6: Status bit 0 holds the result of the most recently received word. It is 1 only when that word had no parity or stop error and the received byte equals both the applied pattern and the memory output.
- R7: Status bit 1 is set when any received frame of the current run has a parity error, and it stays set until the next start.
- R8: Status bit 2 is set when any received frame of the current run has a low stop bit, and it stays set. After such a frame the receiver waits for the line to return high before it looks for another start bit.
- R9: Status bit 4 is set when any memory read-back differs from the applied pattern. Status bit 3 is set when any word fails for any reason. Both bits stay set until the next start.
- R10: Status bit 7 is high while a test runs and bit 6 mirrors `done`. Bit 5 is 0. `done` rises when the last word has been checked. `go` is high only when `done` is high and no word of the run failed.
- R11: An accepted start clears status bits 0 to 4 and `done` on the next clock.
- R12: When the parameter FLT_EN is 1, bit FLT_BIT of address FLT_ADDR always reads as FLT_VAL. A self-test on such a memory then ends with `go` low and status bit 4 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode | input | 1 | 1 = self-test owns the memory, 0 = functional access |
| start | input | 1 | One-clock pulse that begins a self-test run |
| fn_we | input | 1 | Functional write enable |
| fn_addr | input | ADDR_W | Functional address |
| fn_wdata | input | DATA_W | Functional write data |
| fn_rdata | output | DATA_W | Registered read data |
| ser_out | output | 1 | Serial frame output |
| ser_in | input | 1 | Serial frame return, normally tied to ser_out |
| done | output | 1 | Run complete; go and status are final |
| go | output | 1 | Pass result, valid while done is high |
| status | output | 8 | Self-test status flags |

## Verification
The properties assume that `ser_in` carries the frames that `ser_out` sent, corrupted in at most a single bit period at a time, and that `test_mode` stays high for the whole of a run. The bench honours this. It drives `test_mode` low only after `done` has risen. It damages a frame only by inverting the return line for exactly one bit period, aligned to the start bit it has just seen on `ser_out`. It pulses `start` for a single clock, away from the clock edge.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_WRITE,
    CS_READ,
    CS_SEND,
    CS_WAIT
  } ctl_state_e;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_RUN,
    RS_HOLD
  } rx_state_e;

  localparam int unsigned SB_PASS = 0;
  localparam int unsigned SB_PERR = 1;
  localparam int unsigned SB_FERR = 2;
  localparam int unsigned SB_FAIL = 3;
  localparam int unsigned SB_MEMF = 4;
  localparam int unsigned SB_DONE = 6;
  localparam int unsigned SB_BUSY = 7;

  // next state of a left-shifting generator with the given tap mask
  function automatic logic [7:0] lfsr_step8(input logic [7:0] s, input logic [7:0] taps);
    return {s[6:0], ^(s & taps)};
  endfunction

endpackage

// File: rtl/mbist_mem.sv
module mbist_mem #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter bit          FLT_EN   = 1'b0,
  parameter int unsigned FLT_ADDR = 0,
  parameter int unsigned FLT_BIT  = 0,
  parameter bit          FLT_VAL  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] raw_word;
  logic [DATA_W-1:0] seen_word;

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign raw_word = cells[addr];

  generate
    if (FLT_EN) begin : g_fault
      always_comb begin
        seen_word = raw_word;
        if (addr == ADDR_W'(FLT_ADDR)) seen_word[FLT_BIT] = FLT_VAL;
      end
    end else begin : g_clean
      assign seen_word = raw_word;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= seen_word;
  end

endmodule

// File: rtl/mbist_ser_tx.sv
module mbist_ser_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CPB    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              line,
  output logic              busy
);
  localparam int unsigned FRAME_W = DATA_W + 3;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);
  localparam int unsigned CNT_W   = (CPB > 1) ? $clog2(CPB) : 1;

  logic [FRAME_W-2:0] pend;
  logic [BIT_W-1:0]   left;
  logic [CNT_W-1:0]   cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line <= 1'b1;
      busy <= 1'b0;
      pend <= '0;
      left <= '0;
      cyc  <= '0;
    end else if (!busy) begin
      if (start) begin
        line <= 1'b0;
        pend <= {1'b1, ^data, data};
        left <= BIT_W'(FRAME_W - 1);
        cyc  <= CNT_W'(CPB - 1);
        busy <= 1'b1;
      end
    end else if (cyc != '0) begin
      cyc <= cyc - 1'b1;
    end else if (left == '0) begin
      busy <= 1'b0;
    end else begin
      line <= pend[0];
      pend <= pend >> 1;
      left <= left - 1'b1;
      cyc  <= CNT_W'(CPB - 1);
    end
  end

endmodule

// File: rtl/mbist_ser_rx.sv
module mbist_ser_rx
  import mbist_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CPB    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int unsigned FRAME_W = DATA_W + 3;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);
  localparam int unsigned CNT_W   = (CPB > 1) ? $clog2(CPB) : 1;
  localparam int unsigned HALF    = (CPB / 2) - 1;
  localparam logic [BIT_W-1:0] IDX_PAR  = BIT_W'(DATA_W + 1);
  localparam logic [BIT_W-1:0] IDX_STOP = BIT_W'(DATA_W + 2);

  rx_state_e        st;
  logic [CNT_W-1:0] cyc;
  logic [BIT_W-1:0] idx;
  logic             par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RS_IDLE;
      cyc   <= '0;
      idx   <= '0;
      par_q <= 1'b0;
      data  <= '0;
      valid <= 1'b0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        RS_IDLE: begin
          if (!line) begin
            st  <= RS_RUN;
            cyc <= CNT_W'(HALF);
            idx <= '0;
          end
        end
        RS_RUN: begin
          if (cyc != '0) begin
            cyc <= cyc - 1'b1;
          end else begin
            cyc <= CNT_W'(CPB - 1);
            idx <= idx + 1'b1;
            if (idx == '0) begin
              if (line) st <= RS_IDLE;          // glitch, not a start bit
            end else if (idx == IDX_PAR) begin
              par_q <= line;
            end else if (idx == IDX_STOP) begin
              valid <= 1'b1;
              perr  <= (^data) ^ par_q;
              ferr  <= ~line;
              st    <= line ? RS_IDLE : RS_HOLD;
            end else begin
              data <= {line, data[DATA_W-1:1]};
            end
          end
        end
        default: begin
          if (line) st <= RS_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned NUM_PAT = 16,
  parameter logic [7:0]  SEED    = 8'hA5,
  parameter logic [7:0]  TAPS    = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              start,
  input  logic              tx_busy,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              tx_start,
  output logic              busy,
  output logic              done,
  output logic              go,
  output logic [7:0]        status
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_PAT - 1);

  ctl_state_e        st;
  logic [ADDR_W-1:0] idx;
  logic [7:0]        pat;
  logic [DATA_W-1:0] held;
  logic              f_pass, f_perr, f_ferr, f_fail, f_memf;
  logic              accept, word_ok, mem_ok;

  assign accept    = (st == CS_IDLE) && start && test_mode;
  assign mem_ok    = (held == DATA_W'(pat));
  assign word_ok   = (rx_data == DATA_W'(pat)) && (rx_data == held) && !rx_perr && !rx_ferr;
  assign mem_we    = (st == CS_WRITE);
  assign mem_addr  = idx;
  assign mem_wdata = DATA_W'(pat);
  assign tx_start  = (st == CS_SEND) && !tx_busy;
  assign busy      = (st != CS_IDLE);
  assign go        = done && !f_fail;

  always_comb begin
    status          = '0;
    status[SB_PASS] = f_pass;
    status[SB_PERR] = f_perr;
    status[SB_FERR] = f_ferr;
    status[SB_FAIL] = f_fail;
    status[SB_MEMF] = f_memf;
    status[SB_DONE] = done;
    status[SB_BUSY] = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= CS_IDLE;
      idx    <= '0;
      pat    <= SEED;
      held   <= '0;
      done   <= 1'b0;
      f_pass <= 1'b0;
      f_perr <= 1'b0;
      f_ferr <= 1'b0;
      f_fail <= 1'b0;
      f_memf <= 1'b0;
    end else begin
      case (st)
        CS_IDLE: begin
          if (accept) begin
            st     <= CS_WRITE;
            idx    <= '0;
            pat    <= SEED;
            done   <= 1'b0;
            f_pass <= 1'b0;
            f_perr <= 1'b0;
            f_ferr <= 1'b0;
            f_fail <= 1'b0;
            f_memf <= 1'b0;
          end
        end
        CS_WRITE: st <= CS_READ;
        CS_READ:  st <= CS_SEND;
        CS_SEND: begin
          if (!tx_busy) begin
            held <= mem_rdata;
            st   <= CS_WAIT;
          end
        end
        default: begin
          if (rx_valid) begin
            f_pass <= word_ok;
            f_perr <= f_perr | rx_perr;
            f_ferr <= f_ferr | rx_ferr;
            f_fail <= f_fail | !word_ok | !mem_ok;
            f_memf <= f_memf | !mem_ok;
            if (idx == LAST) begin
              st   <= CS_IDLE;
              done <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              pat <= lfsr_step8(pat, TAPS);
              st  <= CS_WRITE;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mbist_frame_top.sv
module mbist_frame_top #(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned NUM_PAT       = 16,
  parameter int unsigned CLKS_PER_BIT  = 4,
  parameter logic [7:0]  SEED          = 8'hA5,
  parameter logic [7:0]  TAPS          = 8'hB8,
  parameter bit          FLT_EN        = 1'b0,
  parameter int unsigned FLT_ADDR      = 0,
  parameter int unsigned FLT_BIT       = 0,
  parameter bit          FLT_VAL       = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              start,
  input  logic              fn_we,
  input  logic [ADDR_W-1:0] fn_addr,
  input  logic [DATA_W-1:0] fn_wdata,
  output logic [DATA_W-1:0] fn_rdata,
  output logic              ser_out,
  input  logic              ser_in,
  output logic              done,
  output logic              go,
  output logic [7:0]        status
);
  logic              t_we;
  logic [ADDR_W-1:0] t_addr;
  logic [DATA_W-1:0] t_wdata;
  logic              m_we;
  logic [ADDR_W-1:0] m_addr;
  logic [DATA_W-1:0] m_wdata;
  logic [DATA_W-1:0] m_rdata;
  logic              tx_start, tx_busy, busy;
  logic              rx_valid, rx_perr, rx_ferr;
  logic [DATA_W-1:0] rx_data;

  // test mode owns the memory port
  assign m_we     = test_mode ? t_we    : fn_we;
  assign m_addr   = test_mode ? t_addr  : fn_addr;
  assign m_wdata  = test_mode ? t_wdata : fn_wdata;
  assign fn_rdata = m_rdata;

  mbist_mem #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLT_EN(FLT_EN),
    .FLT_ADDR(FLT_ADDR), .FLT_BIT(FLT_BIT), .FLT_VAL(FLT_VAL)
  ) u_mem (
    .clk(clk), .rst_n(rst_n), .we(m_we), .addr(m_addr),
    .wdata(m_wdata), .rdata(m_rdata)
  );

  mbist_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PAT(NUM_PAT),
    .SEED(SEED), .TAPS(TAPS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
    .tx_busy(tx_busy), .mem_rdata(m_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .mem_we(t_we), .mem_addr(t_addr), .mem_wdata(t_wdata),
    .tx_start(tx_start), .busy(busy), .done(done), .go(go), .status(status)
  );

  mbist_ser_tx #(.DATA_W(DATA_W), .CPB(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .data(m_rdata),
    .line(ser_out), .busy(tx_busy)
  );

  mbist_ser_rx #(.DATA_W(DATA_W), .CPB(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .line(ser_in), .valid(rx_valid),
    .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
  );

endmodule

// File: rtl/mbist_frame_chk.sv
module mbist_frame_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       test_mode,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       go,
  input logic       ser_out,
  input logic       rx_valid,
  input logic       rx_perr,
  input logic       rx_ferr,
  input logic [7:0] status
);

  // R10
  go_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> done);

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R5
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_out);

  // R5
  rx_only_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> busy);

  // R7
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_perr) |=> (status[1] && !status[0]));

  // R8
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ferr) |=> (status[2] && !status[0]));

  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && test_mode && !busy) |=> (busy && !done && status[4:0] == 5'b0));

  // R3
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !test_mode && !busy) |=> !busy);

endmodule

bind mbist_frame_top mbist_frame_chk u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
  .busy(busy), .done(done), .go(go), .ser_out(ser_out),
  .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .status(status)
);

// File: tb/mbist_frame_top_bench.sv
module mbist_frame_top_bench;
  localparam int CPB     = 4;
  localparam int NPAT    = 16;
  localparam int FRAME_N = 11;

  function automatic logic [7:0] pat_at(input int n);
    logic [7:0] s;
    s = 8'hA5;
    for (int i = 0; i < n; i++) s = (s << 1) | {7'b0, s[7] ^ s[5] ^ s[4] ^ s[3]};
    return s;
  endfunction

  localparam logic [7:0] P5     = pat_at(5);
  localparam bit         STK_V  = ~P5[0];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       test_mode = 1'b0, start = 1'b0, fn_we = 1'b0;
  logic [3:0] fn_addr = '0;
  logic [7:0] fn_wdata = '0;
  logic [7:0] fn_rdata;
  logic       ser_out, done, go, flip = 1'b0;
  logic [7:0] status;
  wire        ser_in = ser_out ^ flip;

  logic       f_test_mode = 1'b0, f_start = 1'b0;
  logic [3:0] f_addr = '0;
  logic [7:0] f_rdata, f_status;
  logic       f_ser, f_done, f_go;

  int n_cmp = 0;
  int n_bad = 0;

  mbist_frame_top u_mbist_frame_top (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
    .fn_we(fn_we), .fn_addr(fn_addr), .fn_wdata(fn_wdata), .fn_rdata(fn_rdata),
    .ser_out(ser_out), .ser_in(ser_in), .done(done), .go(go), .status(status)
  );

  mbist_frame_top #(.FLT_EN(1'b1), .FLT_ADDR(5), .FLT_BIT(0), .FLT_VAL(STK_V)) u_mbist_frame_top_flt (
    .clk(clk), .rst_n(rst_n), .test_mode(f_test_mode), .start(f_start),
    .fn_we(1'b0), .fn_addr(f_addr), .fn_wdata(8'h00), .fn_rdata(f_rdata),
    .ser_out(f_ser), .ser_in(f_ser), .done(f_done), .go(f_go), .status(f_status)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic run_test();
    @(negedge clk);
    test_mode = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(status[7] && !done, "R10 busy during run", {24'b0, status}, 32'h80);
    wait (done);
    @(negedge clk);
  endtask

  task automatic read_word(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    fn_addr = a;
    @(negedge clk);
    d = fn_rdata;
  endtask

  // invert the return line for one bit period of a chosen frame
  task automatic corrupt(input int frame, input int bitno);
    for (int f = 0; f < frame; f++) begin
      @(negedge ser_out);
      repeat (FRAME_N * CPB) @(posedge clk);
    end
    @(negedge ser_out);
    repeat (bitno * CPB) @(posedge clk);
    #1 flip = 1'b1;
    repeat (CPB) @(posedge clk);
    #1 flip = 1'b0;
  endtask

  task automatic t_reset();
    chk(status == 8'h00, "R1 status", {24'b0, status}, 32'h0);
    chk(!done && !go, "R1 done/go", {30'b0, done, go}, 32'h0);
    chk(ser_out == 1'b1, "R1 idle line", {31'b0, ser_out}, 32'h1);
  endtask

  task automatic t_functional();
    logic [7:0] d;
    for (int a = 0; a < 3; a++) begin
      @(negedge clk);
      fn_we = 1'b1; fn_addr = 4'(a + 9); fn_wdata = 8'(8'h3C + a * 17);
    end
    @(negedge clk);
    fn_we = 1'b0;
    for (int a = 0; a < 3; a++) begin
      read_word(4'(a + 9), d);
      chk(d == 8'(8'h3C + a * 17), "R2 functional read", {24'b0, d}, {24'b0, 8'(8'h3C + a * 17)});
    end
  endtask

  task automatic t_start_ignored();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(status == 8'h00 && !done, "R3 start ignored in functional mode", {24'b0, status}, 32'h0);
  endtask

  task automatic t_clean_run();
    logic [10:0] fr;
    logic [7:0]  d;
    fn_we = 1'b1; fn_addr = 4'd2; fn_wdata = 8'h00;
    fork
      run_test();
      begin
        @(negedge ser_out);
        repeat (2) @(posedge clk);
        for (int b = 0; b < FRAME_N; b++) begin
          #1 fr[b] = ser_out;
          repeat (CPB) @(posedge clk);
        end
      end
    join
    chk(fr[0] == 1'b0, "R5 start bit", {31'b0, fr[0]}, 32'h0);
    chk(fr[8:1] == pat_at(0), "R5 data LSB first", {24'b0, fr[8:1]}, {24'b0, pat_at(0)});
    chk(fr[9] == ^pat_at(0), "R5 even parity", {31'b0, fr[9]}, {31'b0, ^pat_at(0)});
    chk(fr[10] == 1'b1, "R5 stop bit", {31'b0, fr[10]}, 32'h1);
    chk(status == 8'h41, "R6 R10 clean status", {24'b0, status}, 32'h41);
    chk(go == 1'b1, "R10 go on clean run", {31'b0, go}, 32'h1);
    fn_we = 1'b0;
    @(negedge clk);
    test_mode = 1'b0;
    for (int a = 0; a < NPAT; a++) begin
      read_word(4'(a), d);
      chk(d == pat_at(a), (a == 2) ? "R3 functional write ignored in test" : "R4 pattern in memory",
          {24'b0, d}, {24'b0, pat_at(a)});
    end
  endtask

  task automatic t_parity_error();
    fork
      run_test();
      corrupt(0, 9);
    join
    chk(status == 8'h4B, "R7 parity error flags", {24'b0, status}, 32'h4B);
    chk(go == 1'b0, "R7 no-go on parity error", {31'b0, go}, 32'h0);
  endtask

  task automatic t_stop_error();
    fork
      run_test();
      corrupt(NPAT - 1, 10);
    join
    chk(status == 8'h4C, "R8 R6 stop error on last word", {24'b0, status}, 32'h4C);
    chk(go == 1'b0, "R8 no-go on stop error", {31'b0, go}, 32'h0);
  endtask

  task automatic t_restart();
    run_test();
    chk(status == 8'h41 && go, "R11 restart clears flags", {24'b0, status}, 32'h41);
  endtask

  task automatic t_fault();
    logic [7:0] d;
    @(negedge clk);
    f_test_mode = 1'b1; f_start = 1'b1;
    @(negedge clk);
    f_start = 1'b0;
    wait (f_done);
    @(negedge clk);
    chk(f_status == 8'h59, "R12 R9 stuck bit flags", {24'b0, f_status}, 32'h59);
    chk(f_go == 1'b0, "R12 no-go with stuck bit", {31'b0, f_go}, 32'h0);
    f_test_mode = 1'b0;
    f_addr = 4'd5;
    @(negedge clk);
    @(negedge clk);
    d = f_rdata;
    chk(d == {P5[7:1], STK_V}, "R12 stuck bit visible", {24'b0, d}, {24'b0, P5[7:1], STK_V});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_functional();
    t_start_ignored();
    t_clean_run();
    t_parity_error();
    t_stop_error();
    t_restart();
    t_fault();
    finish_run();
  end

endmodule